// File: doc/BRIEF.md
# SD Card Command Issue Unit

This unit sends one command to an attached card each time software writes the command register with its start bit set. It presents the 6-bit command index and the 32-bit argument to the card side, then waits for a completion handshake. The handshake returns a byte count, up to sixteen response bytes and an error flag. The unit checks the byte count against the response length the command asked for. It packs a good response into four 32-bit words and records the outcome in sticky status flags.

Commands that carry the pending-mode bit are stored but never sent. The start bit clears itself once the command has been handled, so software can poll the command register to see when the unit is free again. Status flags stay set until software clears them with a write-one-to-clear mask.

Top module: `sdc_cmd_issue`

## Requirements
- R1: A command write with bit 10 set and bit 9 clear, made while idle, raises `card_req` from the next cycle. While `card_req` is high, `card_idx` shows bits [5:0] of the written word and `card_arg` shows `arg_in` as sampled at the write. `card_req` stays high until the cycle in which `card_vld` is seen.
- R2: `cmd_rdata` returns the last accepted command word. Bit 10 reads 1 while the command is outstanding and reads 0 from the cycle after `card_vld`. A write with bit 10 clear is stored as written and starts nothing.
- R3: The timeout flag (status bit 2) is set when `card_err` comes with `card_vld`, whatever the command bits are. It is also set when a response is expected (bit 6) and the byte count is 0.
- R4: With a response expected, a byte count of exactly 16 is always accepted. A count of exactly 4 is accepted only when bit 7 (long) is clear. Every other count sets the timeout flag.
- R5: An accepted response packs bytes big-endian: word k is made of bytes 4k, 4k+1, 4k+2 and 4k+3, with byte 4k in bits [31:24]. Byte i is taken from `card_bytes[8i+7:8i]`, and word k is output on `rsp_words[32k+31:32k]`.
- R6: An accepted 4-byte response loads word 0 and writes zero to words 1, 2 and 3.
- R7: An accepted 16-byte response has bit 0 of word 3 forced to 0.
- R8: An accepted response sets the response-received flag (status bit 6). A command that expects no response and completes without `card_err` sets the command-sent flag (status bit 7). Each completion sets exactly one of bits 2, 6 and 7.
- R9: A command write with both bit 10 and bit 9 set does not raise `card_req` and leaves the status unchanged. It reads back with bit 10 already clear on the next cycle.
- R10: The response words change only on an accepted response. A timeout or a command that expects no response leaves them as they were.
- R11: Status flags are sticky. A `stat_clr` pulse clears the flags whose bits are set in `stat_clr_mask`. A flag that is set in the same cycle as its clear stays set.
- R12: A command write that arrives while a command is outstanding is ignored: the outstanding index, the argument and the read-back value are all kept.
- R13: After reset the command read-back, the status, the response words and `card_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: index [5:0], response [6], long [7], pending [9], start [10] |
| arg_in | input | 32 | Command argument, sampled with the write |
| cmd_rdata | output | 32 | Command register read-back |
| stat_clr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 8 | Write-one-to-clear mask for the status flags |
| status | output | 8 | Sticky flags: timeout [2], response received [6], command sent [7] |
| card_req | output | 1 | Command outstanding towards the card |
| card_idx | output | 6 | Command index for the card |
| card_arg | output | 32 | Command argument for the card |
| card_vld | input | 1 | Card completion strobe |
| card_err | input | 1 | Card reports no response |
| card_len | input | 5 | Response byte count |
| card_bytes | input | 128 | Response bytes, byte i at [8i+7:8i] |
| rsp_words | output | 128 | Response words, word k at [32k+31:32k] |

## Verification
The assertions assume that the card side raises `card_vld` only while `card_req` is high and holds it for a single cycle. They also assume that `card_len` and `card_bytes` are valid in that cycle. The bench's card responder keeps to these rules: it waits until it sees `card_req`, then pulses `card_vld` once after a chosen delay. Byte counts outside the two legal values, the error flag and a clear that coincides with a completion are driven on purpose. Command writes during an outstanding command are also driven on purpose.

// File: rtl/sdc_pkg.sv
// Shared constants and types for the SD command issue unit.
// Assumes a 32-bit command word and an 8-bit status vector.
package sdc_pkg;
    localparam int CMD_W   = 32;
    localparam int IDX_W   = 6;
    localparam int B_RSP   = 6;
    localparam int B_LONG  = 7;
    localparam int B_PEND  = 9;
    localparam int B_START = 10;
    localparam int ST_W    = 8;
    localparam int ST_TO   = 2;
    localparam int ST_RSP  = 6;
    localparam int ST_SENT = 7;

    typedef enum logic {S_IDLE, S_WAIT} sdc_state_e;

    typedef struct packed {
        logic timeout;
        logic rsp_done;
        logic sent;
    } sdc_evt_t;
endpackage

// File: rtl/sdc_ctrl.sv
// Command register and issue sequencer.
// Holds the last accepted command word, starts a card request on the start
// bit, and clears the start bit once the card completes. Assumes card_vld
// arrives only while card_req is high.
module sdc_ctrl
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [31:0]      arg_in,
    input  logic             card_vld,
    output logic [CMD_W-1:0] cmd_q,
    output logic             card_req,
    output logic [IDX_W-1:0] card_idx,
    output logic [31:0]      card_arg,
    output logic             done,
    output logic             want_rsp,
    output logic             want_long
);
    sdc_state_e  state_q;
    logic [31:0] arg_q;

    // Accept writes while idle, sequence one request, clear start on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cmd_q   <= '0;
            arg_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (cmd_we) begin
                        arg_q <= arg_in;
                        if (cmd_wdata[B_START] && !cmd_wdata[B_PEND]) begin
                            cmd_q   <= cmd_wdata;
                            state_q <= S_WAIT;
                        end else begin
                            cmd_q          <= cmd_wdata;
                            cmd_q[B_START] <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (card_vld) begin
                        cmd_q[B_START] <= 1'b0;
                        state_q        <= S_IDLE;
                    end
                end
            endcase
        end
    end

    // Card-side view of the outstanding command.
    always_comb begin
        card_req  = (state_q == S_WAIT);
        card_idx  = cmd_q[IDX_W-1:0];
        card_arg  = arg_q;
        done      = card_req && card_vld;
        want_rsp  = cmd_q[B_RSP];
        want_long = cmd_q[B_LONG];
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_vld |=> card_req && $stable(card_idx) && $stable(card_arg));
    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_req) |-> !cmd_q[B_START]);
    p_pend_noissue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !card_req && cmd_wdata[B_START] && cmd_wdata[B_PEND] |=> !card_req);
    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        card_req && !card_vld |=> $stable(cmd_q));
endmodule

// File: rtl/sdc_rsp_asm.sv
// Response checker and word assembler.
// Judges the completion against the requested response length, raises one
// outcome event and packs accepted bytes big-endian into the word store.
// Assumes card_len and card_bytes are valid in the cycle done is high.
module sdc_rsp_asm
    import sdc_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int N_WORDS     = 4,
    parameter int SHORT_BYTES = 4,
    parameter int LEN_W       = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      done,
    input  logic                      want_rsp,
    input  logic                      want_long,
    input  logic                      card_err,
    input  logic [LEN_W-1:0]          card_len,
    input  logic [N_WORDS*WORD_W-1:0] card_bytes,
    output sdc_evt_t                  evt,
    output logic [N_WORDS*WORD_W-1:0] rsp_words
);
    localparam int BPW         = WORD_W / 8;
    localparam int RSP_BYTES   = N_WORDS * BPW;
    localparam int SHORT_WORDS = SHORT_BYTES / BPW;

    logic is_full, is_short, len_ok, upd;
    logic [N_WORDS*WORD_W-1:0] nxt_all;

    // Length judgement and outcome event for this completion.
    always_comb begin
        is_full  = (card_len == LEN_W'(RSP_BYTES));
        is_short = (card_len == LEN_W'(SHORT_BYTES)) && !want_long;
        len_ok   = is_full || is_short;
        evt.timeout  = done && (card_err || (want_rsp && !len_ok));
        evt.rsp_done = done && !card_err && want_rsp && len_ok;
        evt.sent     = done && !card_err && !want_rsp;
        upd          = evt.rsp_done;
    end

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] nxt;
        // Pack bytes of word k, first byte most significant.
        always_comb begin
            nxt = '0;
            for (int j = 0; j < BPW; j++) begin
                nxt[WORD_W-1-8*j -: 8] = card_bytes[8*(k*BPW+j) +: 8];
            end
            if (!is_full) begin
                if (k >= SHORT_WORDS) nxt = '0;
            end else if (k == N_WORDS-1) begin
                nxt[0] = 1'b0;
            end
        end
        assign nxt_all[k*WORD_W +: WORD_W] = nxt;
    end

    // Response word store, loaded on an accepted response only.
    always_ff @(posedge clk) begin
        if (!rst_n)   rsp_words <= '0;
        else if (upd) rsp_words <= nxt_all;
    end

    p_short_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd && !is_full |=> rsp_words[N_WORDS*WORD_W-1:SHORT_WORDS*WORD_W] == '0);
    p_keep_words_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(rsp_words));
    p_long_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd && is_full |=> !rsp_words[(N_WORDS-1)*WORD_W]);
endmodule

// File: rtl/sdc_status.sv
// Sticky status flags with write-one-to-clear.
// A set in the same cycle as a clear wins. Assumes at most one event per cycle.
module sdc_status
    import sdc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  sdc_evt_t        evt,
    input  logic            stat_clr,
    input  logic [ST_W-1:0] stat_clr_mask,
    output logic [ST_W-1:0] status
);
    logic [ST_W-1:0] set_vec, clr_vec;

    // Map outcome events onto their flag positions.
    always_comb begin
        set_vec          = '0;
        set_vec[ST_TO]   = evt.timeout;
        set_vec[ST_RSP]  = evt.rsp_done;
        set_vec[ST_SENT] = evt.sent;
        clr_vec          = stat_clr ? stat_clr_mask : '0;
    end

    // Sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.timeout, evt.rsp_done, evt.sent}));
    p_timeout_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TO] && !(stat_clr && stat_clr_mask[ST_TO]) |=> status[ST_TO]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rsp_done |=> status[ST_RSP]);
endmodule

// File: rtl/sdc_cmd_issue.sv
// Top of the SD command issue unit.
// Joins the command sequencer, response assembler and status flags.
// Assumes a single-cycle card_vld that comes only while card_req is high.
module sdc_cmd_issue
    import sdc_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int N_WORDS     = 4,
    parameter int SHORT_BYTES = 4,
    parameter int LEN_W       = $clog2(N_WORDS * WORD_W / 8) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_we,
    input  logic [31:0]               cmd_wdata,
    input  logic [31:0]               arg_in,
    output logic [31:0]               cmd_rdata,
    input  logic                      stat_clr,
    input  logic [7:0]                stat_clr_mask,
    output logic [7:0]                status,
    output logic                      card_req,
    output logic [5:0]                card_idx,
    output logic [31:0]               card_arg,
    input  logic                      card_vld,
    input  logic                      card_err,
    input  logic [LEN_W-1:0]          card_len,
    input  logic [N_WORDS*WORD_W-1:0] card_bytes,
    output logic [N_WORDS*WORD_W-1:0] rsp_words
);
    logic     done, want_rsp, want_long;
    sdc_evt_t evt;

    sdc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .arg_in    (arg_in),
        .card_vld  (card_vld),
        .cmd_q     (cmd_rdata),
        .card_req  (card_req),
        .card_idx  (card_idx),
        .card_arg  (card_arg),
        .done      (done),
        .want_rsp  (want_rsp),
        .want_long (want_long)
    );

    sdc_rsp_asm #(
        .WORD_W      (WORD_W),
        .N_WORDS     (N_WORDS),
        .SHORT_BYTES (SHORT_BYTES),
        .LEN_W       (LEN_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .want_rsp   (want_rsp),
        .want_long  (want_long),
        .card_err   (card_err),
        .card_len   (card_len),
        .card_bytes (card_bytes),
        .evt        (evt),
        .rsp_words  (rsp_words)
    );

    sdc_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (evt),
        .stat_clr      (stat_clr),
        .stat_clr_mask (stat_clr_mask),
        .status        (status)
    );
endmodule

// File: tb/tb_sdc_cmd_issue.sv
module tb_sdc_cmd_issue;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_we = 1'b0;
    logic [31:0]  cmd_wdata = '0;
    logic [31:0]  arg_in = '0;
    logic [31:0]  cmd_rdata;
    logic         stat_clr = 1'b0;
    logic [7:0]   stat_clr_mask = '0;
    logic [7:0]   status;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic         card_vld = 1'b0;
    logic         card_err = 1'b0;
    logic [4:0]   card_len = '0;
    logic [127:0] card_bytes = '0;
    logic [127:0] rsp_words;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    // Behavioural reference state.
    bit          m_busy;
    logic [31:0] m_cmd, m_arg;
    logic [7:0]  m_stat, ns;
    logic [31:0] m_w [4];

    sdc_cmd_issue dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: next state from the inputs seen at each edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_busy = 0; m_cmd = '0; m_arg = '0; m_stat = '0;
            foreach (m_w[k]) m_w[k] = '0;
        end else begin
            ns = m_stat;
            if (stat_clr) ns = ns & ~stat_clr_mask;
            if (m_busy) begin
                if (card_vld) begin
                    if (card_err) ns[2] = 1'b1;
                    else if (!m_cmd[6]) ns[7] = 1'b1;
                    else if (card_len == 16 || (card_len == 4 && !m_cmd[7])) begin
                        for (int k = 0; k < 4; k++) begin
                            m_w[k] = '0;
                            if (card_len == 16 || k == 0)
                                for (int j = 0; j < 4; j++)
                                    m_w[k] = {m_w[k][23:0], card_bytes[8*(4*k+j) +: 8]};
                        end
                        if (card_len == 16) m_w[3][0] = 1'b0;
                        ns[6] = 1'b1;
                    end else ns[2] = 1'b1;
                    m_busy = 0;
                    m_cmd[10] = 1'b0;
                end
            end else if (cmd_we) begin
                m_cmd = cmd_wdata;
                m_arg = arg_in;
                if (cmd_wdata[10] && !cmd_wdata[9]) m_busy = 1;
                else m_cmd[10] = 1'b0;
            end
            m_stat = ns;
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R1 card_req", card_req, m_busy);
            if (m_busy) begin
                chk("R1 card_idx", card_idx, m_cmd[5:0]);
                chk("R1 card_arg", card_arg, m_arg);
            end
            chk("R2 cmd_rdata", cmd_rdata, m_cmd);
            chk("R11 status", status, m_stat);
            chk("R5 rsp_words", rsp_words, {m_w[3], m_w[2], m_w[1], m_w[0]});
        end
    end

    function automatic logic [127:0] mk_bytes(input logic [7:0] base);
        logic [127:0] b;
        for (int i = 0; i < 16; i++) b[8*i +: 8] = base + 8'(i);
        return b;
    endfunction

    task automatic clear(input logic [7:0] m);
        @(negedge clk); stat_clr = 1'b1; stat_clr_mask = m;
        @(negedge clk); stat_clr = 1'b0; stat_clr_mask = '0;
    endtask

    task automatic run_cmd(input logic [31:0] c, input logic [31:0] a, input int dly,
                           input logic err, input int len, input logic [127:0] b,
                           input logic [7:0] clr_m);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = c; arg_in = a;
        @(negedge clk); cmd_we = 1'b0;
        if (c[10] && !c[9]) begin
            chk("R1 req raised", card_req, 1'b1);
            chk("R1 index", card_idx, c[5:0]);
            chk("R1 argument", card_arg, a);
            chk("R2 start reads high while busy", cmd_rdata[10], 1'b1);
            repeat (dly) @(negedge clk);
            card_vld = 1'b1; card_err = err; card_len = 5'(len); card_bytes = b;
            if (clr_m != 0) begin stat_clr = 1'b1; stat_clr_mask = clr_m; end
            @(negedge clk);
            card_vld = 1'b0; card_err = 1'b0; stat_clr = 1'b0; stat_clr_mask = '0;
            chk("R2 start self-clears", cmd_rdata, c & ~32'h400);
        end
    endtask

    localparam logic [127:0] W_SHORT = 128'h0000_0000_0000_0000_0000_0000_A0A1_A2A3;
    localparam logic [127:0] W_LONG  = 128'h3C3D_3E3E_3839_3A3B_3435_3637_3031_3233;
    localparam logic [127:0] W_L16   = 128'h5C5D_5E5E_5859_5A5B_5455_5657_5051_5253;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R13 reset status", status, 8'h00);
        chk("R13 reset cmd", cmd_rdata, 32'h0);
        chk("R13 reset words", rsp_words, 128'h0);
        chk("R13 reset req", card_req, 1'b0);

        run_cmd(32'h451, 32'hDEAD_BEEF, 0, 0, 4, mk_bytes(8'hA0), 0);
        chk("R8 response flag", status, 8'h40);
        chk("R5 short packing", rsp_words[31:0], 32'hA0A1_A2A3);
        chk("R6 upper words zero", rsp_words, W_SHORT);
        clear(8'hFF);
        chk("R11 clear all", status, 8'h00);

        run_cmd(32'h4C2, 32'h1234_5678, 2, 0, 16, mk_bytes(8'h30), 0);
        chk("R5 long packing", rsp_words, W_LONG);
        chk("R7 last bit zero", rsp_words[96], 1'b0);
        chk("R8 long response flag", status, 8'h40);

        run_cmd(32'h4C3, 32'h0, 1, 0, 4, mk_bytes(8'h70), 0);
        chk("R4 long with 4 bytes", status, 8'h44);
        chk("R10 words kept on timeout", rsp_words, W_LONG);
        clear(8'h40);
        chk("R11 selective clear", status, 8'h04);
        clear(8'h04);

        run_cmd(32'h445, 32'h0, 3, 0, 0, mk_bytes(8'h70), 0);
        chk("R3 zero bytes", status, 8'h04);
        clear(8'hFF);

        run_cmd(32'h446, 32'h0, 0, 0, 7, mk_bytes(8'h70), 0);
        chk("R4 odd count", status, 8'h04);
        clear(8'hFF);

        run_cmd(32'h447, 32'h0, 1, 1, 4, mk_bytes(8'h70), 0);
        chk("R3 card error", status, 8'h04);
        chk("R10 words kept on error", rsp_words, W_LONG);
        clear(8'hFF);

        run_cmd(32'h447, 32'h0, 0, 0, 16, mk_bytes(8'h50), 0);
        chk("R4 16 bytes on short request", status, 8'h40);
        chk("R4 16 bytes loaded", rsp_words, W_L16);
        clear(8'hFF);

        run_cmd(32'h408, 32'hCAFE_0000, 2, 0, 0, mk_bytes(8'h70), 0);
        chk("R8 sent flag", status, 8'h80);
        chk("R10 words kept without response", rsp_words, W_L16);

        run_cmd(32'h605, 32'h0, 0, 0, 0, '0, 0);
        chk("R9 pending readback", cmd_rdata, 32'h205);
        repeat (3) @(negedge clk);
        chk("R9 no request", card_req, 1'b0);
        chk("R9 status unchanged", status, 8'h80);

        run_cmd(32'h451, 32'h0, 1, 0, 4, mk_bytes(8'hA0), 8'hC0);
        chk("R11 set wins over clear", status, 8'h40);

        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 32'h452; arg_in = 32'h1111_1111;
        @(negedge clk); cmd_wdata = 32'h4C9; arg_in = 32'h2222_2222;
        @(negedge clk); cmd_we = 1'b0;
        chk("R12 readback kept", cmd_rdata, 32'h452);
        chk("R12 index kept", card_idx, 6'd18);
        chk("R12 argument kept", card_arg, 32'h1111_1111);
        card_vld = 1'b1; card_len = 5'd4; card_bytes = mk_bytes(8'h10);
        @(negedge clk); card_vld = 1'b0;
        chk("R12 first command completes", cmd_rdata, 32'h052);

        run_cmd(32'h041, 32'h0, 0, 0, 0, '0, 0);
        chk("R2 plain store", cmd_rdata, 32'h041);
        chk("R2 no start no request", card_req, 1'b0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule